// File: doc/BRIEF.md
# Link-to-Transaction Packet Assembler

This block sits between a link layer and a transaction layer. It takes one fixed-size dword packet per cycle, each tagged with start-of-transaction, end-of-transaction, a 4-bit kind and a data-error flag. It keeps a single bit of framing state that says whether a transaction is open. Packets that belong to an open transaction, or that open one, are forwarded one cycle later. Packets that arrive while nothing is open are dropped without a trace.

Each transaction ends with exactly one completion pulse: commit if none of its packets carried an error, abort otherwise. The pulse carries the kind latched from the opening packet. A completion never leaves before the end packet has been seen. It normally appears two cycles after the end packet. A new start that arrives while a transaction is still open ends the open one with an abort. A transaction that reaches `MAX_BEATS` packets without an end marker is closed with an abort and a protocol-error flag.

Top module: `link_txn_assembler`

## Requirements
- R1: After synchronous active-high reset, no transaction is open, and `beat_valid`, `done_commit`, `done_abort` and `proto_err` are all 0.
- R2: A packet presented with `in_valid`=1 that has `in_sop`=1, or that arrives while a transaction is open, appears on `beat_valid`/`beat_data` in the next cycle. `beat_first` is 1 exactly for the start packet.
- R3: A packet without a start marker that arrives while no transaction is open is discarded. It produces no beat and no completion, and it leaves the block closed, so a later end marker without a start also completes nothing.
- R4: The kind reported on `done_type` is the `in_type` value of the start packet of the transaction being completed.
- R5: A transaction whose packets all have `in_err`=0 completes with a `done_commit` pulse.
- R6: If any packet of a transaction, the start packet included, has `in_err`=1, the transaction completes with a `done_abort` pulse.
- R7: No completion pulse is issued for a transaction whose end has not been seen. Each transaction yields exactly one single-cycle pulse.
- R8: A completion is pulsed two cycles after the cycle in which its end packet is presented. Completions leave in order, at most one per cycle.
- R9: A start packet that arrives while a transaction is open aborts the open transaction, reporting the old kind, and opens a new transaction.
- R10: When the `MAX_BEATS`-th packet of a transaction carries no end marker, the transaction closes with `done_abort` and `proto_err` pulsed together.
- R11: A start-and-end packet that arrives while a transaction is open causes two completions. The abort of the old transaction comes first, at the normal time, and the new transaction's completion follows one cycle later. Any completion queued behind these two is delayed by one cycle as well.
- R12: `done_commit` and `done_abort` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A packet is present this cycle |
| in_sop | input | 1 | Packet opens a transaction |
| in_eop | input | 1 | Packet ends a transaction |
| in_type | input | TW | Transaction kind, used on the start packet |
| in_err | input | 1 | Packet carries a data error |
| in_data | input | DW | Packet payload |
| beat_valid | output | 1 | Forwarded beat present |
| beat_first | output | 1 | Forwarded beat is the start packet |
| beat_data | output | DW | Forwarded payload |
| done_commit | output | 1 | Transaction committed (one-cycle pulse) |
| done_abort | output | 1 | Transaction aborted (one-cycle pulse) |
| done_type | output | TW | Kind of the completed transaction |
| proto_err | output | 1 | Completion was forced by a missing end marker |

## Verification
Two completions can fall due in the same cycle. This happens when a start-and-end packet arrives while a transaction is already open: the preempted transaction aborts and the new one-packet transaction also completes. The bench provokes this directly and then follows it at once with another one-packet transaction, so that a third completion queues behind the deferred one. Random traffic with frequent start markers hits the same case many times. Each pulse is judged against a reference queue. The cycle in which a pulse is due is the later of two cycles: two cycles after its end packet, or one cycle after the previous pulse. Kind, outcome and protocol flag are compared in that cycle.

// File: rtl/link_txn_assembler.sv
module link_txn_assembler #(
  parameter int DW = 32,
  parameter int TW = 4,
  parameter int MAX_BEATS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic [TW-1:0] in_type,
  input  logic          in_err,
  input  logic [DW-1:0] in_data,
  output logic          beat_valid,
  output logic          beat_first,
  output logic [DW-1:0] beat_data,
  output logic          done_commit,
  output logic          done_abort,
  output logic [TW-1:0] done_type,
  output logic          proto_err
);
  localparam int CW = $clog2(MAX_BEATS + 1);

  logic          open_q;
  logic [TW-1:0] kind_q;
  logic          bad_q;
  logic [CW-1:0] cnt_q;

  wire          take    = in_valid && (in_sop || open_q);
  wire          preempt = in_valid && in_sop && open_q;
  wire [CW-1:0] cnt_nx  = in_sop ? CW'(1) : cnt_q + CW'(1);
  wire          overlen = take && !in_eop && (cnt_nx == CW'(MAX_BEATS));
  wire          finish  = take && (in_eop || overlen);
  wire          bad_nx  = (in_sop ? 1'b0 : bad_q) | in_err;
  wire [TW-1:0] kind_nx = in_sop ? in_type : kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      kind_q <= '0;
      bad_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (take) begin
      open_q <= !finish;
      kind_q <= kind_nx;
      bad_q  <= bad_nx;
      cnt_q  <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_valid <= 1'b0;
      beat_first <= 1'b0;
      beat_data  <= '0;
    end else begin
      beat_valid <= take;
      beat_first <= take && in_sop;
      if (take) beat_data <= in_data;
    end
  end

  // completion slots: a is always the older one
  logic          a_v, a_c, a_p, b_v, b_c, b_p, s_v, s_c, s_p;
  logic [TW-1:0] a_t, b_t, s_t;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_v <= 1'b0; a_c <= 1'b0; a_p <= 1'b0; a_t <= '0;
      b_v <= 1'b0; b_c <= 1'b0; b_p <= 1'b0; b_t <= '0;
    end else begin
      b_v <= preempt && finish;
      b_c <= !bad_nx && !overlen;
      b_p <= overlen;
      b_t <= kind_nx;
      if (preempt) begin
        a_v <= 1'b1; a_c <= 1'b0; a_p <= 1'b0; a_t <= kind_q;
      end else begin
        a_v <= finish; a_c <= !bad_nx && !overlen; a_p <= overlen; a_t <= kind_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_v <= 1'b0; s_c <= 1'b0; s_p <= 1'b0; s_t <= '0;
      done_commit <= 1'b0; done_abort <= 1'b0; proto_err <= 1'b0; done_type <= '0;
    end else if (s_v) begin
      done_commit <= s_c;
      done_abort  <= !s_c;
      proto_err   <= s_p;
      done_type   <= s_t;
      s_v <= a_v; s_c <= a_c; s_p <= a_p; s_t <= a_t;
    end else begin
      done_commit <= a_v && a_c;
      done_abort  <= a_v && !a_c;
      proto_err   <= a_v && a_p;
      done_type   <= a_t;
      s_v <= b_v; s_c <= b_c; s_p <= b_p; s_t <= b_t;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $fell(rst) |-> !beat_valid && !done_commit && !done_abort && !proto_err);

  // R2
  beat_forward_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && (in_sop || open_q) |=> beat_valid && (beat_data == $past(in_data)));

  // R3
  garbage_drop_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_sop && !open_q |=> !beat_valid && !open_q);

  // R10
  proto_abort_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> done_abort);

  // R11
  spill_single_chk: assert property (@(posedge clk) disable iff (rst)
    s_v |-> !b_v);

  // R12
  outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_commit, done_abort}));

  // R7
  done_needs_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (done_commit || done_abort) |-> $past(a_v || s_v));
endmodule

// File: tb/link_txn_assembler_test.sv
module link_txn_assembler_test;
  localparam int MAXB = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_sop = 0, in_eop = 0, in_err = 0;
  logic [3:0] in_type = '0;
  logic [31:0] in_data = '0;
  logic beat_valid, beat_first, done_commit, done_abort, proto_err;
  logic [31:0] beat_data;
  logic [3:0] done_type;

  link_txn_assembler #(.DW(32), .TW(4), .MAX_BEATS(MAXB)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_type(in_type), .in_err(in_err), .in_data(in_data),
    .beat_valid(beat_valid), .beat_first(beat_first), .beat_data(beat_data),
    .done_commit(done_commit), .done_abort(done_abort), .done_type(done_type),
    .proto_err(proto_err));

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int checks = 0, failures = 0;
  bit finished = 0;

  bit m_open = 0, m_err = 0;
  bit [3:0] m_type = 0;
  int m_cnt = 0;
  int q_e[$];
  bit q_c[$], q_p[$];
  bit [3:0] q_t[$];
  string q_tag[$];
  int last_done = -10;
  bit eb_v = 0, eb_f = 0;
  logic [31:0] eb_d = '0;
  string eb_tag = "R1";

  function automatic int due_edge(int e);
    return (e + 1 > last_done + 1) ? e + 1 : last_done + 1;
  endfunction

  task automatic push_done(int e, bit c, bit [3:0] t, bit p, string tag);
    q_e.push_back(e); q_c.push_back(c); q_t.push_back(t); q_p.push_back(p); q_tag.push_back(tag);
  endtask

  task automatic check_outputs();
    checks++;
    if (beat_valid !== eb_v || (eb_v && (beat_first !== eb_f || beat_data !== eb_d))) begin
      failures++;
      $display("FAIL %s beat: got v=%0b f=%0b d=%h expected v=%0b f=%0b d=%h",
               eb_tag, beat_valid, beat_first, beat_data, eb_v, eb_f, eb_d);
    end
    if (q_e.size() > 0 && cyc == due_edge(q_e[0])) begin
      checks++;
      if (done_commit !== q_c[0] || done_abort !== !q_c[0] || done_type !== q_t[0] ||
          proto_err !== q_p[0]) begin
        failures++;
        $display("FAIL %s/R4/R8/R12 done: got c=%0b a=%0b t=%0d p=%0b expected c=%0b a=%0b t=%0d p=%0b",
                 q_tag[0], done_commit, done_abort, done_type, proto_err,
                 q_c[0], !q_c[0], q_t[0], q_p[0]);
      end
      last_done = cyc;
      void'(q_e.pop_front()); void'(q_c.pop_front()); void'(q_t.pop_front());
      void'(q_p.pop_front()); void'(q_tag.pop_front());
    end else if (done_commit || done_abort || proto_err) begin
      checks++; failures++;
      $display("FAIL R7 unexpected completion: got c=%0b a=%0b p=%0b expected none",
               done_commit, done_abort, proto_err);
    end
  endtask

  task automatic step(bit v, bit sop, bit eop, bit [3:0] typ, bit err, logic [31:0] d);
    int e, cnt;
    bit take, pre, er, over;
    bit [3:0] ty;
    @(negedge clk);
    check_outputs();
    e = cyc + 1;
    take = v && (sop || m_open);
    pre = v && sop && m_open;
    eb_v = take; eb_f = sop; eb_d = d; eb_tag = take ? "R2" : "R3";
    if (pre) push_done(e, 1'b0, m_type, 1'b0, "R9");
    if (take) begin
      cnt = sop ? 1 : m_cnt + 1;
      er = (sop ? 1'b0 : m_err) | err;
      ty = sop ? typ : m_type;
      over = !eop && cnt == MAXB;
      if (eop || over) begin
        push_done(e, !er && !over, ty, over,
                  over ? "R10" : (pre ? "R11" : (er ? "R6" : "R5")));
        m_open = 0;
      end else m_open = 1;
      m_cnt = cnt; m_err = er; m_type = ty;
    end
    in_valid = v; in_sop = sop; in_eop = eop; in_type = typ; in_err = err; in_data = d;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog: got hung run expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (beat_valid || done_commit || done_abort || proto_err) begin
      failures++;
      $display("FAIL R1 reset outputs: got %0b%0b%0b%0b expected 0000",
               beat_valid, done_commit, done_abort, proto_err);
    end
    rst = 0;
    // R5 R4 plain commit
    step(1,1,0,4'd5,0,32'h11); step(1,0,0,0,0,32'h12); step(1,0,1,0,0,32'h13);
    // R6 error mid-transaction
    step(1,1,0,4'd9,0,32'h21); step(1,0,0,0,1,32'h22); step(1,0,1,0,0,32'h23);
    // R3 garbage, including a stray end marker
    step(1,0,0,4'd3,1,32'hdead); step(1,0,1,4'd3,0,32'hbeef); step(0,0,0,0,0,0);
    // R9 restart
    step(1,1,0,4'd2,0,32'h31); step(1,0,0,0,0,32'h32); step(1,1,0,4'd7,0,32'h33);
    step(1,0,1,0,0,32'h34);
    // R11 restart with single packet, then another single packet
    step(1,1,0,4'd3,0,32'h41); step(1,1,1,4'd4,0,32'h42); step(1,1,1,4'd6,0,32'h43);
    step(0,0,0,0,0,0); step(0,0,0,0,0,0);
    // R6 error on start of single packet
    step(1,1,1,4'd8,1,32'h51);
    // R10 overlength, then ignored tail
    step(1,1,0,4'd12,0,32'h60);
    for (int i = 1; i < MAXB; i++) step(1,0,0,0,0,32'h60 + i);
    step(1,0,0,0,0,32'h99); step(1,0,1,0,0,32'h9a); step(0,0,0,0,0,0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom % 10) < 8;
      bit s = ($urandom % 10) < 2;
      bit en = ($urandom % 4) == 0;
      bit er = ($urandom % 10) == 0;
      step(v, s, en, 4'($urandom), er, $urandom);
    end
    for (int i = 0; i < 6; i++) step(0,0,0,0,0,0);
    checks++;
    if (q_e.size() != 0) begin
      failures++;
      $display("FAIL R7 pending completions: got %0d expected 0", q_e.size());
    end
    finish_run();
  end
endmodule